// File: doc/BRIEF.md
# Two-Phase Bridge Pulse Sequencer

The sequencer produces the four gate commands of two full bridges that drive a two-phase capacitive motor: a positive and an inverted command for each phase. All timing is counted in cycles of a fast reference clock. A register bank supplies a period code, an optional period offset, a pulse width, a phase displacement, a direction bit, a dead-time selection, two phase enables and an 11-bit burst length.

A strobed write of a non-zero burst length starts a burst of exactly that many output periods. Phase 2 is displaced from phase 1, and the direction bit decides which phase leads. Extra dead time can be inserted ahead of each high interval, so the positive and inverted command of a phase are never high together. A write of zero, the sleep input or the end of the count stops the burst and drives every output low. Period, width, displacement, dead time and direction are sampled only at the start of a burst and at each period boundary.

Top module: `bridge_seq`

## Requirements
- R1: The output period P is `period_i` reference clocks plus `offset_i` when `cal_mode_i` is 2'b00. For any other `cal_mode_i` the offset is ignored and P equals `period_i`.
- R2: A cycle with `load_i` high and `pulse_cnt_i` non-zero starts a burst with the position counter at 0. Exactly `pulse_cnt_i` periods follow, and then all outputs return low.
- R3: A cycle with `load_i` high and `pulse_cnt_i` zero ends any burst, and all four outputs are low from the next clock edge.
- R4: With position q within the period, the positive output of a phase is high for dt <= q < H. H is P/2 (rounded down) for width code 0 and equals the code otherwise.
- R5: The inverted output of a phase is high for H+dt <= q < P, so a phase drives both outputs low during dead time.
- R6: The phase offset S is P/4 (rounded down) for shift code 0 and equals the code otherwise. With `dir_i`=0 (forward), phase 2 lags: its position is (pos-S) mod P and phase 1 uses pos. With `dir_i`=1 (reverse), phase 1 lags by S and phase 2 uses pos.
- R7: The dead time dt is 0 when `dt_en_i` is low. Otherwise dt is 2, 4, 6 or 8 clocks for `dt_sel_i` = 00, 01, 10, 11.
- R8: A phase whose enable is low holds both of its outputs low. The other phase is unaffected.
- R9: Changes to period, offset, calibration mode, width, shift, dead time or direction during a burst take effect only from the next period boundary.
- R10: `sleep_i` high ends any burst, like a zero write. It has priority over `load_i`, and outputs stay low until a new load.
- R11: The positive and inverted outputs of one phase are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Stop and hold outputs low |
| load_i | input | 1 | Burst length write strobe |
| pulse_cnt_i | input | 11 | Burst length in periods |
| period_i | input | 9 | Period code in reference clocks |
| offset_i | input | 3 | Period extension |
| cal_mode_i | input | 2 | Calibration mode, 00 = off |
| width_i | input | 8 | High time code |
| shift_i | input | 8 | Phase displacement code |
| dir_i | input | 1 | 0 forward, 1 reverse |
| dt_en_i | input | 1 | Dead time enable |
| dt_sel_i | input | 2 | Dead time selection |
| ph1_en_i | input | 1 | Phase 1 enable |
| ph2_en_i | input | 1 | Phase 2 enable |
| ph1_p_o | output | 1 | Phase 1 positive command |
| ph1_n_o | output | 1 | Phase 1 inverted command |
| ph2_p_o | output | 1 | Phase 2 positive command |
| ph2_n_o | output | 1 | Phase 2 inverted command |

## Verification
The bench runs bursts with the following settings:
- default width and shift codes, with and without an offset and with calibration active; these separate the derived P/2 and P/4 values from the literal codes and show whether the offset is gated.
- both directions, to show which phase is delayed.
- each dead-time code, to check the position of each edge.
- a disabled phase, to check that only that phase is held low.
- a width change in mid-burst, to check that new values wait for the boundary.
- a zero write and a sleep request in mid-burst, to check the stop paths.

Rising-edge counts and spacing confirm the burst length and the period.

// File: rtl/bridge_seq_pkg.sv
package bridge_seq_pkg;
  typedef enum logic [1:0] {
    CAL_OFF   = 2'b00,
    CAL_STEP  = 2'b01,
    CAL_SWEEP = 2'b10,
    CAL_RSVD  = 2'b11
  } cal_mode_e;

  function automatic logic [3:0] dt_clocks(input logic en, input logic [1:0] sel);
    return en ? ({2'b00, sel} + 4'd1) << 1 : 4'd0;
  endfunction
endpackage

// File: rtl/bridge_seq_timebase.sv
module bridge_seq_timebase
  import bridge_seq_pkg::*;
#(
  parameter int PER_W  = 9,
  parameter int OFS_W  = 3,
  parameter int CODE_W = 8,
  parameter int CNT_W  = 11,
  localparam int PW    = PER_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  pulse_cnt_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [1:0]        cal_mode_i,
  input  logic [CODE_W-1:0] width_i,
  input  logic [CODE_W-1:0] shift_i,
  input  logic              dir_i,
  input  logic              dt_en_i,
  input  logic [1:0]        dt_sel_i,
  output logic              run_o,
  output logic [PW-1:0]     pos_o,
  output logic [PW-1:0]     per_o,
  output logic [PW-1:0]     hi_o,
  output logic [PW-1:0]     sh_o,
  output logic [PW-1:0]     dt_o,
  output logic              dir_o,
  output logic [CNT_W-1:0]  rem_o
);
  logic [PW-1:0] per_n, hi_n, sh_n, dt_n;
  logic          stop, boundary;

  always_comb begin
    per_n = PW'(period_i);
    if (cal_mode_e'(cal_mode_i) == CAL_OFF) per_n = per_n + PW'(offset_i);
    hi_n  = (width_i == '0) ? (per_n >> 1) : PW'(width_i);
    sh_n  = (shift_i == '0) ? (per_n >> 2) : PW'(shift_i);
    dt_n  = PW'(dt_clocks(dt_en_i, dt_sel_i));
  end

  assign stop     = sleep_i || (load_i && pulse_cnt_i == '0);
  assign boundary = run_o && (pos_o == per_o - PW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0;
      rem_o <= '0;
      pos_o <= '0;
      per_o <= '0;
      hi_o  <= '0;
      sh_o  <= '0;
      dt_o  <= '0;
      dir_o <= 1'b0;
    end else if (stop) begin
      run_o <= 1'b0;
      rem_o <= '0;
      pos_o <= '0;
    end else if (load_i || boundary) begin
      per_o <= per_n;
      hi_o  <= hi_n;
      sh_o  <= sh_n;
      dt_o  <= dt_n;
      dir_o <= dir_i;
      pos_o <= '0;
      if (load_i) begin
        run_o <= 1'b1;
        rem_o <= pulse_cnt_i;
      end else begin
        rem_o <= rem_o - CNT_W'(1);
        if (rem_o == CNT_W'(1)) run_o <= 1'b0;
      end
    end else if (run_o) begin
      pos_o <= pos_o + PW'(1);
    end
  end
endmodule

// File: rtl/bridge_seq_phase.sv
module bridge_seq_phase #(
  parameter int PW = 10
) (
  input  logic          run_i,
  input  logic          en_i,
  input  logic [PW-1:0] pos_i,
  input  logic [PW-1:0] per_i,
  input  logic [PW-1:0] hi_i,
  input  logic [PW-1:0] dly_i,
  input  logic [PW-1:0] dt_i,
  output logic          pos_o,
  output logic          neg_o
);
  logic [PW-1:0] q;
  logic          act;

  assign q   = (pos_i >= dly_i) ? pos_i - dly_i : pos_i + per_i - dly_i;
  assign act = run_i && en_i;

  assign pos_o = act && (q >= dt_i) && (q < hi_i);
  assign neg_o = act && (q >= hi_i + dt_i) && (q < per_i);
endmodule

// File: rtl/bridge_seq.sv
module bridge_seq #(
  parameter int PER_W  = 9,
  parameter int OFS_W  = 3,
  parameter int CODE_W = 8,
  parameter int CNT_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  pulse_cnt_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [1:0]        cal_mode_i,
  input  logic [CODE_W-1:0] width_i,
  input  logic [CODE_W-1:0] shift_i,
  input  logic              dir_i,
  input  logic              dt_en_i,
  input  logic [1:0]        dt_sel_i,
  input  logic              ph1_en_i,
  input  logic              ph2_en_i,
  output logic              ph1_p_o,
  output logic              ph1_n_o,
  output logic              ph2_p_o,
  output logic              ph2_n_o
);
  localparam int PW = PER_W + 1;

  logic             run;
  logic [PW-1:0]    pos, per, hi, sh, dt;
  logic             dir;
  logic [CNT_W-1:0] rem;
  logic [1:0]       en, p, n;

  assign en = {ph2_en_i, ph1_en_i};

  bridge_seq_timebase #(
    .PER_W(PER_W), .OFS_W(OFS_W), .CODE_W(CODE_W), .CNT_W(CNT_W)
  ) u_tb (
    .clk_i, .rst_ni, .sleep_i, .load_i, .pulse_cnt_i, .period_i, .offset_i,
    .cal_mode_i, .width_i, .shift_i, .dir_i, .dt_en_i, .dt_sel_i,
    .run_o(run), .pos_o(pos), .per_o(per), .hi_o(hi), .sh_o(sh),
    .dt_o(dt), .dir_o(dir), .rem_o(rem)
  );

  for (genvar k = 0; k < 2; k++) begin : g_ph
    // forward delays phase 2, reverse delays phase 1
    logic [PW-1:0] dly;
    assign dly = ((k == 1) != dir) ? sh : '0;

    bridge_seq_phase #(.PW(PW)) u_ph (
      .run_i(run), .en_i(en[k]), .pos_i(pos), .per_i(per), .hi_i(hi),
      .dly_i(dly), .dt_i(dt), .pos_o(p[k]), .neg_o(n[k])
    );
  end

  assign ph1_p_o = p[0];
  assign ph1_n_o = n[0];
  assign ph2_p_o = p[1];
  assign ph2_n_o = n[1];
endmodule

// File: rtl/bridge_seq_chk.sv
module bridge_seq_chk #(
  parameter int PW    = 10,
  parameter int CNT_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sleep_i,
  input logic             load_i,
  input logic [CNT_W-1:0] pulse_cnt_i,
  input logic             ph1_en_i,
  input logic             ph2_en_i,
  input logic             ph1_p_o,
  input logic             ph1_n_o,
  input logic             ph2_p_o,
  input logic             ph2_n_o,
  input logic             run,
  input logic [PW-1:0]    pos,
  input logic [PW-1:0]    per,
  input logic [CNT_W-1:0] rem
);
  logic [3:0] outs;
  assign outs = {ph1_p_o, ph1_n_o, ph2_p_o, ph2_n_o};

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ph1_p_o && ph1_n_o) && !(ph2_p_o && ph2_n_o)); // R11

  AST_ZERO_WRITE_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && pulse_cnt_i == '0) |=> (outs == 4'b0)); // R3

  AST_SLEEP_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (!run && outs == 4'b0)); // R10

  AST_LOAD_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !sleep_i && pulse_cnt_i != '0) |=> (run && pos == '0 && rem == $past(pulse_cnt_i))); // R2

  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !load_i && !sleep_i && pos == per - PW'(1)) |=> (rem == $past(rem) - CNT_W'(1))); // R2

  AST_PH1_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph1_en_i |-> (!ph1_p_o && !ph1_n_o)); // R8

  AST_PH2_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph2_en_i |-> (!ph2_p_o && !ph2_n_o)); // R8
endmodule

bind bridge_seq bridge_seq_chk #(.PW(PER_W + 1), .CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .sleep_i, .load_i, .pulse_cnt_i, .ph1_en_i, .ph2_en_i,
  .ph1_p_o, .ph1_n_o, .ph2_p_o, .ph2_n_o,
  .run(run), .pos(pos), .per(per), .rem(rem)
);

// File: tb/bridge_seq_test.sv
module bridge_seq_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sleep_i = 1'b0, load_i = 1'b0;
  logic [10:0] pulse_cnt_i = '0;
  logic [8:0]  period_i = 9'd20;
  logic [2:0]  offset_i = '0;
  logic [1:0]  cal_mode_i = '0;
  logic [7:0]  width_i = '0, shift_i = '0;
  logic        dir_i = 1'b0, dt_en_i = 1'b0;
  logic [1:0]  dt_sel_i = '0;
  logic        ph1_en_i = 1'b1, ph2_en_i = 1'b1;
  logic        ph1_p_o, ph1_n_o, ph2_p_o, ph2_n_o;

  int vectors = 0, fails = 0, cyc = 0;
  string req = "R2";

  // reference model state
  int m_run = 0, m_rem = 0, m_pos = 0, m_per = 0, m_hi = 0, m_sh = 0, m_dt = 0, m_dir = 0;
  int rises = 0, last_rise = -1, rise_gap = 0, ph2_seen = 0;

  always #2 clk = ~clk;

  bridge_seq uut (
    .clk_i(clk), .rst_ni, .sleep_i, .load_i, .pulse_cnt_i, .period_i, .offset_i,
    .cal_mode_i, .width_i, .shift_i, .dir_i, .dt_en_i, .dt_sel_i,
    .ph1_en_i, .ph2_en_i, .ph1_p_o, .ph1_n_o, .ph2_p_o, .ph2_n_o
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic check(input string r, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d exp %0d", r, got, exp);
    end
  endtask

  function automatic void latch_cfg();
    m_per = period_i + ((cal_mode_i == 2'b00) ? offset_i : 0);
    m_hi  = (width_i == 0) ? m_per / 2 : width_i;
    m_sh  = (shift_i == 0) ? m_per / 4 : shift_i;
    m_dt  = dt_en_i ? 2 * (dt_sel_i + 1) : 0;
    m_dir = dir_i;
  endfunction

  function automatic bit [1:0] phase_exp(input int dly, input bit en);
    int q;
    q = (m_pos - dly + m_per) % m_per;
    if (!(m_run != 0 && en)) return 2'b00;
    return {bit'(q >= m_dt && q < m_hi), bit'(q >= m_hi + m_dt && q < m_per)};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog got %0d exp 0", cyc);
      summary();
    end
    if (rst_ni) begin
      if (sleep_i || (load_i && pulse_cnt_i == 0)) begin
        m_run = 0; m_rem = 0; m_pos = 0;
      end else if (load_i) begin
        m_run = 1; m_rem = pulse_cnt_i; m_pos = 0; latch_cfg();
      end else if (m_run != 0) begin
        if (m_pos == m_per - 1) begin
          m_pos = 0; m_rem--;
          if (m_rem == 0) m_run = 0;
          latch_cfg();
        end else m_pos++;
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_ni) begin
      bit [1:0] e1, e2;
      e1 = phase_exp(m_dir ? m_sh : 0, ph1_en_i);
      e2 = phase_exp(m_dir ? 0 : m_sh, ph2_en_i);
      check(req, {ph1_p_o, ph1_n_o, ph2_p_o, ph2_n_o}, {e1, e2});
      if ((ph1_p_o & ph1_n_o) | (ph2_p_o & ph2_n_o)) check("R11", 1, 0);
      if (ph1_p_o && m_pos == m_dt && m_dir == 0) begin
        rises++;
        if (last_rise >= 0) rise_gap = cyc - last_rise;
        last_rise = cyc;
      end
      if (ph2_p_o | ph2_n_o) ph2_seen++;
    end
  end

  task automatic start(input int n);
    @(negedge clk);
    pulse_cnt_i = 11'(n);
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_run != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg(input int per, input int ofs, input int cal, input int w,
                     input int s, input int d, input int de, input int ds);
    period_i = 9'(per); offset_i = 3'(ofs); cal_mode_i = 2'(cal);
    width_i = 8'(w); shift_i = 8'(s); dir_i = d[0]; dt_en_i = de[0]; dt_sel_i = 2'(ds);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset", {ph1_p_o, ph1_n_o, ph2_p_o, ph2_n_o}, 0);
    rst_ni = 1'b1;

    // R1: offset applied with calibration off; also default width/shift (R4, R6)
    req = "R1"; cfg(20, 3, 0, 0, 0, 0, 0, 0);
    rises = 0; last_rise = -1; start(3); wait_idle();
    check("R1 period", rise_gap, 23);
    check("R2 count", rises, 3);
    // R1: offset ignored while calibrating
    cfg(20, 3, 2, 0, 0, 0, 0, 0);
    rises = 0; last_rise = -1; start(2); wait_idle();
    check("R1 cal gated", rise_gap, 20);
    // R4 R5: explicit width and shift codes
    req = "R4"; cfg(24, 0, 0, 5, 7, 0, 0, 0); start(3); wait_idle();
    req = "R5"; cfg(31, 0, 0, 13, 0, 0, 0, 0); start(2); wait_idle();
    // R6: reverse direction, explicit and default shift
    req = "R6"; cfg(24, 0, 0, 0, 5, 1, 0, 0); start(3); wait_idle();
    cfg(32, 0, 0, 0, 0, 1, 0, 0); start(2); wait_idle();
    // R7: every dead-time code
    req = "R7";
    for (int k = 0; k < 4; k++) begin
      cfg(40, 0, 0, 0, 0, k % 2, 1, k); start(2); wait_idle();
    end
    // R8: phase 2 disabled
    req = "R8"; ph2_seen = 0; ph2_en_i = 1'b0;
    cfg(20, 0, 0, 0, 0, 0, 0, 0); start(3); wait_idle();
    check("R8 ph2 held", ph2_seen, 0);
    ph2_en_i = 1'b1;
    // R9: width changed mid-period, applies at boundary
    req = "R9"; cfg(30, 0, 0, 0, 0, 0, 0, 0); start(4);
    repeat (5) @(negedge clk);
    width_i = 8'd4; dir_i = 1'b1;
    wait_idle();
    // R2: single-period burst
    req = "R2"; cfg(16, 0, 0, 0, 0, 0, 0, 0);
    rises = 0; last_rise = -1; start(1); wait_idle();
    check("R2 one", rises, 1);
    // R3: zero write mid-burst
    req = "R3"; start(50); repeat (30) @(negedge clk);
    start(0);
    check("R3 stopped", {ph1_p_o, ph1_n_o, ph2_p_o, ph2_n_o}, 0);
    repeat (20) @(negedge clk);
    check("R3 still low", {ph1_p_o, ph1_n_o, ph2_p_o, ph2_n_o}, 0);
    // R10: sleep mid-burst, also beating a load
    req = "R10"; start(50); repeat (25) @(negedge clk);
    sleep_i = 1'b1; pulse_cnt_i = 11'd9; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    check("R10 low", {ph1_p_o, ph1_n_o, ph2_p_o, ph2_n_o}, 0);
    repeat (5) @(negedge clk);
    sleep_i = 1'b0;
    repeat (20) @(negedge clk);
    check("R10 no restart", {ph1_p_o, ph1_n_o, ph2_p_o, ph2_n_o}, 0);
    // R2: long burst near upper range of length field
    req = "R2"; cfg(10, 0, 0, 0, 0, 0, 0, 0);
    rises = 0; last_rise = -1; start(2047); wait_idle();
    check("R2 max", rises, 2047);
    summary();
  end
endmodule